// File: doc/BRIEF.md
# Reconstruction Residual Adder with Pixel Clamp

This unit forms reconstructed pixels for one 8x8 block. A predicted row of eight unsigned 8-bit pixels arrives together with eight signed 16-bit residual samples. Each pixel is widened with zeros and added to its residual. The sum saturates to the signed 16-bit range and is then clamped to 0..255. The eight results are packed back into a 64-bit row. Rows arrive in raster order, one per accepted step, and eight rows make one block.

A per-row enable states whether a residual exists. When it is low, the predicted row goes to the output unchanged and the residual bus is ignored. The output row is registered, so results appear one clock after the input row is accepted. A one-cycle done flag marks the output of the eighth row of each block. The predictor, the inverse transform and the residual source sit outside this unit.

Top module: `rac_recon`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `recon_vld_o`, `blk_done_o` and `recon_row_o` are all zero.
- R2: `recon_vld_o` is high in exactly those cycles that follow a cycle in which `row_vld_i` was high.
- R3: Lane k (k = 0..7) of the predicted row occupies bits 8k+7:8k of `pred_row_i`. Its residual occupies bits 16k+15:16k of `resid_row_i`, as two's complement. Its result occupies bits 8k+7:8k of `recon_row_o`.
- R4: When `resid_en_i` is high and pred + residual lies in 0..255, the output lane equals that sum.
- R5: When `resid_en_i` is high and pred + residual is below 0, the lane outputs 0. This includes a residual of -32768 (0x8000).
- R6: When `resid_en_i` is high and pred + residual is above 255, the lane outputs 255. This includes a residual of +32767 (0x7FFF), which first saturates at 16 bits.
- R7: When `resid_en_i` is low on an accepted row, `recon_row_o` equals `pred_row_i` of that row, whatever `resid_row_i` holds.
- R8: `blk_done_o` is high together with `recon_vld_o` for every eighth accepted row since reset, and low otherwise. Idle cycles between rows do not advance the count.
- R9: In a cycle following one with `row_vld_i` low, `recon_row_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_vld_i | input | 1 | Input row is present this cycle |
| resid_en_i | input | 1 | A residual applies to this row |
| pred_row_i | input | 64 | Eight predicted pixels, lane 0 in the low byte |
| resid_row_i | input | 128 | Eight signed 16-bit residuals, lane 0 in the low half-word |
| recon_vld_o | output | 1 | Reconstructed row is valid |
| recon_row_o | output | 64 | Eight reconstructed pixels, lane 0 in the low byte |
| blk_done_o | output | 1 | The valid row is the last of an 8-row block |

## Verification
The in-module assertions run on every clock. They check that the output valid follows the input valid by one cycle. They check that the done flag never appears without a valid row and never appears two cycles in a row. They also check that the output row holds through idle cycles and that a bypassed row reappears unchanged. The arithmetic needs the bench's scenarios: per-lane clamping at both ends, the saturating extremes and lane ordering with distinct per-lane values. The same applies to block counting across idle gaps and across a reset in the middle of a block.

// File: rtl/rac_pkg.sv
package rac_pkg;
    // default geometry of one reconstruction step
    localparam int unsigned PIX_W_DEF  = 8;
    localparam int unsigned RES_W_DEF  = 16;
    localparam int unsigned LANES_DEF  = 8;
    localparam int unsigned ROWS_DEF   = 8;

    // where an output row comes from
    typedef enum logic {
        SRC_PRED = 1'b0,
        SRC_SUM  = 1'b1
    } row_src_e;
endpackage

// File: rtl/rac_lane.sv
module rac_lane #(
    parameter int unsigned PIX_W = 8,
    parameter int unsigned RES_W = 16
) (
    input  logic [PIX_W-1:0] pred_i,
    input  logic [RES_W-1:0] resid_i,
    output logic [PIX_W-1:0] pix_o
);
    localparam int unsigned SW = RES_W + 1;

    logic signed [SW-1:0]    pext;
    logic signed [SW-1:0]    rext;
    logic signed [SW-1:0]    sum;
    logic        [RES_W-1:0] sat;

    always_comb begin
        pext = {{(SW-PIX_W){1'b0}}, pred_i};
        rext = {resid_i[RES_W-1], resid_i};
        sum  = pext + rext;

        // signed saturation to RES_W bits
        if (sum[SW-1] != sum[SW-2]) begin
            sat = sum[SW-1] ? {1'b1, {(RES_W-1){1'b0}}}
                            : {1'b0, {(RES_W-1){1'b1}}};
        end else begin
            sat = sum[RES_W-1:0];
        end

        // unsigned clamp to the pixel range
        if (sat[RES_W-1]) begin
            pix_o = '0;
        end else if (|sat[RES_W-2:PIX_W]) begin
            pix_o = '1;
        end else begin
            pix_o = sat[PIX_W-1:0];
        end
    end
endmodule

// File: rtl/rac_row_ctr.sv
module rac_row_ctr #(
    parameter int unsigned ROWS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    output logic last_o
);
    localparam int unsigned CW = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam logic [CW-1:0] LAST = CW'(ROWS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        last_o = (cnt_q == LAST);
        cnt_d  = cnt_q;
        if (step_i) begin
            cnt_d = last_o ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R8: the count restarts after the final row of a block
    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && last_o) |=> (cnt_q == '0));

    // R8: idle cycles leave the count alone
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(cnt_q));
endmodule

// File: rtl/rac_recon.sv
module rac_recon
    import rac_pkg::*;
#(
    parameter int unsigned PIX_W = PIX_W_DEF,
    parameter int unsigned RES_W = RES_W_DEF,
    parameter int unsigned LANES = LANES_DEF,
    parameter int unsigned ROWS  = ROWS_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   row_vld_i,
    input  logic                   resid_en_i,
    input  logic [PIX_W*LANES-1:0] pred_row_i,
    input  logic [RES_W*LANES-1:0] resid_row_i,
    output logic                   recon_vld_o,
    output logic [PIX_W*LANES-1:0] recon_row_o,
    output logic                   blk_done_o
);
    localparam int unsigned ROW_W = PIX_W * LANES;

    typedef struct packed {
        logic             vld;
        logic             done;
        logic [ROW_W-1:0] row;
    } out_st_t;

    out_st_t          st_d, st_q;
    logic [ROW_W-1:0] sum_row;
    logic             last_row;
    row_src_e         src;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        rac_lane #(
            .PIX_W (PIX_W),
            .RES_W (RES_W)
        ) u_lane (
            .pred_i  (pred_row_i[k*PIX_W +: PIX_W]),
            .resid_i (resid_row_i[k*RES_W +: RES_W]),
            .pix_o   (sum_row[k*PIX_W +: PIX_W])
        );
    end

    rac_row_ctr #(
        .ROWS (ROWS)
    ) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (row_vld_i),
        .last_o (last_row)
    );

    always_comb begin
        src       = resid_en_i ? SRC_SUM : SRC_PRED;
        st_d      = st_q;
        st_d.vld  = row_vld_i;
        st_d.done = row_vld_i && last_row;
        if (row_vld_i) begin
            st_d.row = (src == SRC_SUM) ? sum_row : pred_row_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign recon_vld_o = st_q.vld;
    assign recon_row_o = st_q.row;
    assign blk_done_o  = st_q.done;

    // R2: an accepted row shows up one cycle later
    p_lat_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        row_vld_i |=> recon_vld_o);
    p_lat_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !row_vld_i |=> !recon_vld_o);

    // R8: done only with a valid row, never twice in a row
    p_done_vld_r8: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done_o |-> recon_vld_o);
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done_o |=> !blk_done_o);

    // R7: a row without residual is passed unchanged
    p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (row_vld_i && !resid_en_i) |=> (recon_row_o == $past(pred_row_i)));

    // R9: the output row holds through idle cycles
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !row_vld_i |=> $stable(recon_row_o));
endmodule

// File: tb/tb_rac_recon.sv
`timescale 1ns/1ps
module tb_rac_recon;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         row_vld_i;
    logic         resid_en_i;
    logic [63:0]  pred_row_i;
    logic [127:0] resid_row_i;
    logic         recon_vld_o;
    logic [63:0]  recon_row_o;
    logic         blk_done_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    rac_recon dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .row_vld_i   (row_vld_i),
        .resid_en_i  (resid_en_i),
        .pred_row_i  (pred_row_i),
        .resid_row_i (resid_row_i),
        .recon_vld_o (recon_vld_o),
        .recon_row_o (recon_row_o),
        .blk_done_o  (blk_done_o)
    );

    // one full block: stimulus and expected result per row
    localparam logic [63:0] T_PRED [8] = '{
        64'h1010101010101010, 64'h0706050403020100,
        64'h8080808080808080, 64'hFFFFFFFFFFFFFFFF,
        64'h8080808080808080, 64'h6464646464646464,
        64'h9C9C9C9C9C9C9C9C, 64'h0123456789ABCDEF };
    localparam logic [127:0] T_RES [8] = '{
        {8{16'h0005}},
        128'h0007_0006_0005_0004_0003_0002_0001_0000,
        {8{16'h8000}}, {8{16'h7FFF}},
        {8{16'hFFFF}}, {8{16'hFF9B}},
        {8{16'h0064}}, {8{16'h7FFF}} };
    localparam logic T_EN [8] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
    localparam logic [63:0] T_EXP [8] = '{
        64'h1515151515151515, 64'h0E0C0A0806040200,
        64'h0000000000000000, 64'hFFFFFFFFFFFFFFFF,
        64'h7F7F7F7F7F7F7F7F, 64'h0000000000000000,
        64'hFFFFFFFFFFFFFFFF, 64'h0123456789ABCDEF };
    localparam string T_REQ [8] = '{"R4", "R3", "R5", "R6", "R4", "R5", "R6", "R7"};

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic en, input logic [63:0] p, input logic [127:0] r);
        row_vld_i   = v;
        resid_en_i  = en;
        pred_row_i  = p;
        resid_row_i = r;
    endtask

    // sends n rows back to back, checking valid and done per row
    task automatic send_rows(input int n, input int done_at);
        for (int i = 0; i < n; i++) begin
            drive(1'b1, 1'b1, 64'h0101010101010101 * (i + 1), {8{16'h0001}});
            @(negedge clk);
            chk("R2", recon_vld_o, 1'b1);
            chk("R8", blk_done_o, (i == done_at));
        end
        drive(1'b0, 1'b0, '0, '0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected <100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b1, 1'b1, '1, '1);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", recon_vld_o, 1'b0);
        chk("R1", blk_done_o, 1'b0);
        chk("R1", recon_row_o, 64'h0);
        drive(1'b0, 1'b0, '0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {recon_vld_o, blk_done_o, recon_row_o}, 66'h0);

        // table walk: one full block, back to back
        for (int i = 0; i < 8; i++) begin
            drive(1'b1, T_EN[i], T_PRED[i], T_RES[i]);
            @(negedge clk);
            chk(T_REQ[i], recon_row_o, T_EXP[i]);
            chk("R2", recon_vld_o, 1'b1);
            chk("R8", blk_done_o, (i == 7));
        end

        // R9 and R2: idle cycle with changed inputs keeps the row
        drive(1'b0, 1'b1, 64'h5555555555555555, {8{16'h0003}});
        @(negedge clk);
        chk("R2", recon_vld_o, 1'b0);
        chk("R8", blk_done_o, 1'b0);
        chk("R9", recon_row_o, 64'h0123456789ABCDEF);

        // R3: mixed lanes, each hitting a different case
        // lanes 7..0: pred FF,00,80,10,7F,01,C8,20
        // residuals : +1,-1,+7FFF,-8000,+0,+0x10,+0x37,-0x20
        drive(1'b1, 1'b1, 64'hFF0080107F01C820,
              128'h0001_FFFF_7FFF_8000_0000_0010_0037_FFE0);
        @(negedge clk);
        chk("R3", recon_row_o, 64'hFF00FF007F11FF00);

        // R7: bypass ignores an extreme residual
        drive(1'b1, 1'b0, 64'h00FF00FF00FF00FF, {8{16'h8000}});
        @(negedge clk);
        chk("R7", recon_row_o, 64'h00FF00FF00FF00FF);
        drive(1'b0, 1'b0, '0, '0);
        @(negedge clk);

        // rows so far in this block: 2; finish it with idle gaps
        send_rows(3, -1);
        repeat (2) @(negedge clk);
        chk("R2", recon_vld_o, 1'b0);
        send_rows(3, 2);

        // reset in the middle of a block restarts the count
        send_rows(3, -1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", recon_vld_o, 1'b0);
        rst_n = 1'b1;
        send_rows(8, 7);
        @(negedge clk);
        chk("R8", blk_done_o, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule